// File: doc/BRIEF.md
# Paged Program Counter Sequencer with Return Stack

This block keeps the instruction fetch address of a small 8-bit controller that uses 14-bit instruction words and an 11-bit program space of 2048 words. On each clock it takes one decoded control-flow command from the decoder and forms the next address. The command is one of: step, skip, load from the ALU result, short jump, short call, long jump, long call, return, or return with immediate. The new address is built from the current address, the instruction word, the two page-select bits of the status register and the ALU result.

Each kind of control transfer builds its upper address bits in its own way. Register writes and short calls force the top bit to zero and take the middle two bits from the page select. Long transfers take every bit from the instruction word. Calls save the address of the next instruction on a return stack with two entries. That stack wraps around, so it never overflows or underflows and raises no flag. Instruction memory, decoding, and the load of W on a return with immediate are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the fetch address is 7FFh. The return stack entries clear to 000h and its pointer returns to its initial position.
- R2: The step command (code 0) loads the fetch address plus 1, wrapping from 7FFh to 000h. The unused codes 9 to 15 behave as step.
- R3: The skip command (code 1) loads the fetch address plus 2, modulo 2048.
- R4: The ALU-load command (code 2) loads {0, page[1:0], alu[7:0]}. The address bits rise from least to most significant.
- R5: The short-jump command (code 3) loads {insn[9], page[1:0], insn[7:0]}. Instruction bit 8 has no effect.
- R6: The short-call command (code 4) loads {0, page[1:0], insn[7:0]} and pushes the fetch address plus 1.
- R7: The long-jump command (code 5) loads insn[10:0].
- R8: The long-call command (code 6) loads insn[10:0] and pushes the fetch address plus 1.
- R9: The return command (code 7) and the return-with-immediate command (code 8) both load the 11-bit value popped from the stack.
- R10: The stack is a circular store of two entries. A push writes into the next slot. A pop returns the most recently written slot and steps back. After pushes A, B, C, three pops return C, B, C. A pop straight after reset returns 000h.
- R11: The value pushed is the fetch address plus 1 modulo 2048, so a call issued at 7FFh saves 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Decoded control-flow command code |
| insn_i | input | 14 | Current instruction word |
| page_i | input | 2 | Page-select bits from the status register |
| alu_i | input | 8 | ALU result for direct counter writes |
| fetch_addr_o | output | 11 | Current fetch address |

## Verification
The bound checker checks several rules on every cycle: the reset vector, the step and skip increments, the formation of addresses for ALU loads and long jumps, and a short call followed at once by a return landing one past the call. The bench's scenarios cover the rest. These include the stack behaviour beyond a single call-return pair: overwriting the older entry on a third push, the wrap-around on pops from an empty stack, and the value a pop returns straight after reset. They also cover the ignored instruction bit in short jumps, the wrap of a pushed address at 7FFh, and the treatment of unused command codes.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [3:0] {
      PC_STEP       = 4'd0,
      PC_SKIP       = 4'd1,
      PC_LOAD_ALU   = 4'd2,
      PC_JMP_SHORT  = 4'd3,
      PC_CALL_SHORT = 4'd4,
      PC_JMP_LONG   = 4'd5,
      PC_CALL_LONG  = 4'd6,
      PC_RET        = 4'd7,
      PC_RET_IMM    = 4'd8
   } pc_cmd_e;

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 11,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      slot_q <= '0;
            else if (push_i) slot_q <= din_i;
         end

         assign dout_o = slot_q;

         logic unused_pop;
         assign unused_pop = pop_i;
      end else begin : g_ring
         localparam int PW   = $clog2(DEPTH);
         localparam int LAST = DEPTH - 1;

         logic [W-1:0]  slot_q [DEPTH];
         logic [PW-1:0] ptr_q;
         logic [PW-1:0] ptr_up;
         logic [PW-1:0] ptr_dn;

         assign ptr_up = (ptr_q == PW'(LAST)) ? '0 : ptr_q + 1'b1;
         assign ptr_dn = (ptr_q == '0) ? PW'(LAST) : ptr_q - 1'b1;
         assign dout_o = slot_q[ptr_q];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ptr_q <= '0;
               for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            end else if (push_i) begin
               slot_q[ptr_up] <= din_i;
               ptr_q          <= ptr_up;
            end else if (pop_i) begin
               ptr_q <= ptr_dn;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
   import pcseq_pkg::*;
#(
   parameter int PC_W   = 11,
   parameter int INSN_W = 14,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 2
) (
   input  logic [PC_W-1:0]   cur_pc_i,
   input  pc_cmd_e           cmd_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [DATA_W-1:0] alu_i,
   input  logic [PC_W-1:0]   pop_data_i,
   output logic [PC_W-1:0]   nxt_pc_o,
   output logic              push_o,
   output logic              pop_o,
   output logic [PC_W-1:0]   ret_addr_o
);

   localparam int JMP_TOP = DATA_W + 1;

   logic [PC_W-1:0] paged_ins;
   logic [PC_W-1:0] paged_alu;
   logic [PC_W-1:0] paged_jmp;

   assign paged_ins  = {1'b0, page_i, insn_i[DATA_W-1:0]};
   assign paged_alu  = {1'b0, page_i, alu_i};
   assign paged_jmp  = {insn_i[JMP_TOP], page_i, insn_i[DATA_W-1:0]};
   assign ret_addr_o = cur_pc_i + PC_W'(1);

   always_comb begin
      nxt_pc_o = cur_pc_i + PC_W'(1);
      push_o   = 1'b0;
      pop_o    = 1'b0;
      unique case (cmd_i)
         PC_SKIP:       nxt_pc_o = cur_pc_i + PC_W'(2);
         PC_LOAD_ALU:   nxt_pc_o = paged_alu;
         PC_JMP_SHORT:  nxt_pc_o = paged_jmp;
         PC_CALL_SHORT: begin
            nxt_pc_o = paged_ins;
            push_o   = 1'b1;
         end
         PC_JMP_LONG:   nxt_pc_o = insn_i[PC_W-1:0];
         PC_CALL_LONG: begin
            nxt_pc_o = insn_i[PC_W-1:0];
            push_o   = 1'b1;
         end
         PC_RET, PC_RET_IMM: begin
            nxt_pc_o = pop_data_i;
            pop_o    = 1'b1;
         end
         default:       nxt_pc_o = cur_pc_i + PC_W'(1);
      endcase
   end

   logic unused_insn_bits;
   assign unused_insn_bits = ^{insn_i[INSN_W-1:PC_W], insn_i[DATA_W]};

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int              PC_W      = 11,
   parameter int              INSN_W    = 14,
   parameter int              DATA_W    = 8,
   parameter int              PAGE_W    = 2,
   parameter int              STK_DEPTH = 2,
   parameter logic [PC_W-1:0] RESET_PC  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cmd_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [DATA_W-1:0] alu_i,
   output logic [PC_W-1:0]   fetch_addr_o
);

   generate
      if (PC_W != DATA_W + PAGE_W + 1) begin : g_bad_split
         $error("PC_W must equal DATA_W + PAGE_W + 1");
      end
      if (INSN_W < PC_W) begin : g_bad_insn
         $error("INSN_W must hold a full long-transfer address");
      end
      if (STK_DEPTH < 1) begin : g_bad_depth
         $error("STK_DEPTH must be at least 1");
      end
   endgenerate

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_d;
   logic [PC_W-1:0] ret_addr;
   logic [PC_W-1:0] pop_data;
   logic            do_push;
   logic            do_pop;
   pc_cmd_e         cmd;

   assign cmd = pc_cmd_e'(cmd_i);

   pcseq_target #(
      .PC_W   (PC_W),
      .INSN_W (INSN_W),
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_target (
      .cur_pc_i   (pc_q),
      .cmd_i      (cmd),
      .insn_i     (insn_i),
      .page_i     (page_i),
      .alu_i      (alu_i),
      .pop_data_i (pop_data),
      .nxt_pc_o   (pc_d),
      .push_o     (do_push),
      .pop_o      (do_pop),
      .ret_addr_o (ret_addr)
   );

   pcseq_stack #(
      .W     (PC_W),
      .DEPTH (STK_DEPTH)
   ) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (do_push),
      .pop_i  (do_pop),
      .din_i  (ret_addr),
      .dout_o (pop_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= pc_d;
   end

   assign fetch_addr_o = pc_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
   parameter int PC_W   = 11,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cmd_i,
   input logic [PC_W-1:0]   insn_lo_i,
   input logic [PAGE_W-1:0] page_i,
   input logic [DATA_W-1:0] alu_i,
   input logic [PC_W-1:0]   fetch_addr_o
);

   // R1
   reset_vector_chk: assert property (@(posedge clk)
      !rst_n |=> fetch_addr_o == {PC_W{1'b1}});

   // R2
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i == 4'd0 |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1)));

   // R3
   skip_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i == 4'd1 |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(2)));

   // R4
   alu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i == 4'd2 |=> fetch_addr_o == {1'b0, $past(page_i), $past(alu_i)});

   // R7
   long_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i == 4'd5 |=> fetch_addr_o == $past(insn_lo_i));

   // R6
   call_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd4 ##1 cmd_i == 4'd7)
      |=> fetch_addr_o == PC_W'($past(fetch_addr_o, 2) + PC_W'(1)));

endmodule

bind pc_sequencer pc_sequencer_chk #(
   .PC_W   (PC_W),
   .DATA_W (DATA_W),
   .PAGE_W (PAGE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_i        (cmd_i),
   .insn_lo_i    (insn_i[PC_W-1:0]),
   .page_i       (page_i),
   .alu_i        (alu_i),
   .fetch_addr_o (fetch_addr_o)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cmd_i = 4'd0;
   logic [13:0] insn_i = '0;
   logic [1:0]  page_i = '0;
   logic [7:0]  alu_i = '0;
   logic [10:0] fetch_addr_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [10:0] m_pc;
   logic [10:0] m_stk [2];
   logic        m_sp;

   always #2.5 clk = ~clk;

   pc_sequencer i_pc_sequencer (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_i        (cmd_i),
      .insn_i       (insn_i),
      .page_i       (page_i),
      .alu_i        (alu_i),
      .fetch_addr_o (fetch_addr_o)
   );

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'd1:       return "R3";
         4'd2:       return "R4";
         4'd3:       return "R5";
         4'd4:       return "R6";
         4'd5:       return "R7";
         4'd6:       return "R8";
         4'd7, 4'd8: return "R9";
         default:    return "R2";
      endcase
   endfunction

   task automatic check(input logic [10:0] got, input logic [10:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: fetch address got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic m_push(input logic [10:0] v);
      m_sp = ~m_sp;
      m_stk[m_sp] = v;
   endtask

   // drive one command, predict, then sample 1 ns after the edge
   task automatic issue(input logic [3:0] c, input logic [13:0] ins,
                        input logic [1:0] pg, input logic [7:0] a, input string tag);
      logic [10:0] e;
      cmd_i = c; insn_i = ins; page_i = pg; alu_i = a;
      case (c)
         4'd1: e = m_pc + 11'd2;
         4'd2: e = {1'b0, pg, a};
         4'd3: e = {ins[9], pg, ins[7:0]};
         4'd4: begin e = {1'b0, pg, ins[7:0]}; m_push(m_pc + 11'd1); end
         4'd5: e = ins[10:0];
         4'd6: begin e = ins[10:0]; m_push(m_pc + 11'd1); end
         4'd7, 4'd8: begin e = m_stk[m_sp]; m_sp = ~m_sp; end
         default: e = m_pc + 11'd1;
      endcase
      @(posedge clk);
      #1;
      check(fetch_addr_o, e, tag);
      m_pc = e;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m_stk[0] = '0; m_stk[1] = '0; m_sp = 1'b0; m_pc = 11'h7FF;
      repeat (3) @(posedge clk);
      #1;
      check(fetch_addr_o, 11'h7FF, "R1");
      rst_n = 1'b1;

      issue(4'd0, '0, 2'd0, 8'h00, "R2 wrap");
      issue(4'd7, '0, 2'd0, 8'h00, "R10 pop after reset");
      issue(4'd5, 14'h07FE, 2'd3, 8'h00, "R7");
      issue(4'd1, '0, 2'd0, 8'h00, "R3 wrap");
      issue(4'd5, 14'h07FF, 2'd0, 8'h00, "R7");
      issue(4'd6, 14'h3923, 2'd1, 8'h00, "R8");
      issue(4'd7, '0, 2'd0, 8'h00, "R11 pushed 000");
      issue(4'd2, '0, 2'd1, 8'h40, "R4");
      issue(4'd4, 14'h0155, 2'd2, 8'h00, "R6");
      issue(4'd4, 14'h0010, 2'd3, 8'h00, "R6");
      issue(4'd6, 14'h07A0, 2'd0, 8'h00, "R8 third push");
      issue(4'd7, '0, 2'd0, 8'h00, "R10 pop newest");
      issue(4'd8, '0, 2'd0, 8'h00, "R9 return imm");
      issue(4'd7, '0, 2'd0, 8'h00, "R10 wrapped pop");
      issue(4'd3, 14'h0333, 2'd0, 8'h00, "R5 bit8 ignored");
      issue(4'd3, 14'h0233, 2'd2, 8'h00, "R5");
      issue(4'hF, '0, 2'd0, 8'h00, "R2 unused code");
      issue(4'd9, '0, 2'd0, 8'h00, "R2 unused code");

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] c;
         c = 4'($urandom_range(0, 15));
         issue(c, 14'($urandom), 2'($urandom), 8'($urandom), tag_of(c));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule